// File: doc/BRIEF.md
# Watchdog Timer with Lockable Disable

This block supervises software by counting up from reset on a prescaled system clock. Software must service it before the counter passes its all-ones value. If it does not, the block raises a one-cycle internal reset request. It also drives an active-low reset-out line for a fixed number of clocks, so that parts outside the chip are reset too.

A service command loads a programmable reload value into the upper half of the counter, clears the lower half and restarts the prescaler. The interval is therefore chosen by the reload value together with a divider select, which picks either a fast or a slow prescale ratio. The watchdog runs after every reset without any software action. Software may turn it off only until it issues the end-of-initialization command. From then on, disable requests have no effect until the next reset.

A sticky status bit shows that the last reset came from the watchdog. It holds until software clears it or an external reset occurs.

Top module: `wdog_lockable`

## Requirements
- R1: After the synchronous reset `rst`: `active_o`=1, `count_o`=0, `rst_out_n_o`=1, `rst_req_o`=0, `wd_status_o`=0; the reload value is 0 and the fast divider is selected.
- R2: While active, `count_o` advances by one every DIV_FAST clocks when the divider select is 0, and every DIV_SLOW clocks when it is 1.
- R3: With reset defaults, the overflow occurs 2^CNT_W x DIV_FAST clocks after reset is released.
- R4: A service command (`svc_i` high for one clock) sets `count_o` to {reload, all zeros in the low half} and restarts the prescaler. The overflow then follows (2^CNT_W - reload x 2^(CNT_W/2)) x divider clocks after that edge.
- R5: A disable command (`dis_i`) issued before any end-of-initialization command sets `active_o` to 0 and freezes `count_o`. No overflow follows.
- R6: After an end-of-initialization command (`eoi_i`), disable commands are ignored and counting and overflow continue. A second end-of-initialization command changes nothing.
- R7: On overflow, `rst_req_o` is high for exactly one clock, and `rst_out_n_o` falls on the same edge and stays low for exactly PULSE_LEN clocks.
- R8: An overflow returns the counter, the enable, the lock, the reload value and the divider select to their reset values.
- R9: An overflow sets `wd_status_o`. It stays set until `stat_clr_i` is applied or `rst` is asserted.
- R10: `cfg_wr_i` stores `cfg_reload_i` as the reload value and `cfg_slow_i` as the divider select (0 = fast, 1 = slow).
- R11: While `rst_out_n_o` is low, all commands and configuration writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_i | input | 1 | Service command |
| dis_i | input | 1 | Disable request |
| eoi_i | input | 1 | End-of-initialization command |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_reload_i | input | CNT_W/2 | Reload value for the counter high half |
| cfg_slow_i | input | 1 | Divider select, 1 = slow |
| stat_clr_i | input | 1 | Clear the watchdog-reset status |
| count_o | output | CNT_W | Current counter value |
| active_o | output | 1 | Watchdog enabled |
| rst_req_o | output | 1 | One-clock internal reset request |
| rst_out_n_o | output | 1 | Active-low reset-out line |
| wd_status_o | output | 1 | Last reset was caused by the watchdog |

## Verification
The assertions assume that every command input is a synchronous level sampled on each rising edge. A command held for several clocks therefore acts several times. The stability property additionally assumes that no service is requested while the watchdog is off. The bench drives each command from the falling edge for one clock only. It issues a service while disabled only at points where the frozen count is not checked. It releases reset before it measures any overflow interval.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Commands after gating by the reset-out pulse
  typedef struct packed {
    logic service;
    logic disable_req;
    logic end_init;
    logic cfg_write;
    logic stat_clear;
  } wd_cmd_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int PRE_W = $clog2(DIV_SLOW);
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim  = slow ? LIM_SLOW : LIM_FAST;
  assign tick = run && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) pre_q <= '0;
    else if (tick)              pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               load,
  input  logic [CNT_W/2-1:0] load_hi,
  input  logic               inc,
  output logic [CNT_W-1:0]   count,
  output logic               at_max
);
  localparam int LO_W = CNT_W - CNT_W/2;

  assign at_max = &count;

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (load)    count <= {load_hi, {LO_W{1'b0}}};
    else if (inc)     count <= count + 1'b1;
  end
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic req,
  output logic out_n,
  output logic busy
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      pcnt  <= '0;
      req   <= 1'b0;
      out_n <= 1'b1;
    end else if (fire && !busy) begin
      busy  <= 1'b1;
      pcnt  <= '0;
      req   <= 1'b1;
      out_n <= 1'b0;
    end else begin
      req <= 1'b0;
      if (busy) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == LAST) begin
          busy  <= 1'b0;
          out_n <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable #(
  parameter int CNT_W     = 16,
  parameter int DIV_FAST  = 2,
  parameter int DIV_SLOW  = 128,
  parameter int PULSE_LEN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               svc_i,
  input  logic               dis_i,
  input  logic               eoi_i,
  input  logic               cfg_wr_i,
  input  logic [CNT_W/2-1:0] cfg_reload_i,
  input  logic               cfg_slow_i,
  input  logic               stat_clr_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               active_o,
  output logic               rst_req_o,
  output logic               rst_out_n_o,
  output logic               wd_status_o
);
  localparam int RL_W = CNT_W / 2;

  wdog_pkg::wd_cmd_t cmd;
  logic              busy;
  logic              tick;
  logic              at_max;
  logic              fire;
  logic              en_q;
  logic              lock_q;
  logic              slow_q;
  logic [RL_W-1:0]   reload_q;
  logic              stat_q;

  always_comb begin
    cmd.service     = svc_i      && !busy;
    cmd.disable_req = dis_i      && !busy;
    cmd.end_init    = eoi_i      && !busy;
    cmd.cfg_write   = cfg_wr_i   && !busy;
    cmd.stat_clear  = stat_clr_i && !busy;
  end

  assign fire = tick && at_max && !busy;

  wdog_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (fire || cmd.service),
    .run     (en_q && !busy),
    .slow    (slow_q),
    .tick    (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (fire),
    .load    (cmd.service),
    .load_hi (reload_q),
    .inc     (tick),
    .count   (count_o),
    .at_max  (at_max)
  );

  wdog_rstgen #(.PULSE_LEN(PULSE_LEN)) u_rg (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .req   (rst_req_o),
    .out_n (rst_out_n_o),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst || fire) begin
      en_q     <= 1'b1;
      lock_q   <= 1'b0;
      slow_q   <= 1'b0;
      reload_q <= '0;
    end else begin
      if (cmd.disable_req && !lock_q) en_q <= 1'b0;
      if (cmd.end_init)               lock_q <= 1'b1;
      if (cmd.cfg_write) begin
        reload_q <= cfg_reload_i;
        slow_q   <= cfg_slow_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 stat_q <= 1'b0;
    else if (fire)           stat_q <= 1'b1;
    else if (cmd.stat_clear) stat_q <= 1'b0;
  end

  assign active_o    = en_q;
  assign wd_status_o = stat_q;
endmodule

// File: rtl/wdog_lockable_chk.sv
module wdog_lockable_chk #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             svc_i,
  input logic             eoi_i,
  input logic [CNT_W-1:0] count_o,
  input logic             active_o,
  input logic             rst_req_o,
  input logic             rst_out_n_o,
  input logic             wd_status_o
);
  localparam int LW = $clog2(PULSE_LEN + 1) + 1;

  logic [LW-1:0] low_cnt;
  logic          seen_eoi;

  always_ff @(posedge clk) begin
    if (rst || rst_out_n_o) low_cnt <= '0;
    else                    low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !rst_out_n_o)      seen_eoi <= 1'b0;
    else if (eoi_i)               seen_eoi <= 1'b1;
  end

  assert_req_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out_n_o) |-> rst_req_o);

  assert_req_single_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  assert_low_width_R7: assert property (@(posedge clk) disable iff (rst)
    !rst_out_n_o |-> (low_cnt < LW'(PULSE_LEN)));

  assert_status_on_req_R9: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> wd_status_o);

  assert_state_restored_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out_n_o) |-> (active_o && count_o == '0));

  assert_frozen_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !svc_i) |=> $stable(count_o));

  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (seen_eoi && active_o && rst_out_n_o) |=> active_o);
endmodule

bind wdog_lockable wdog_lockable_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .svc_i       (svc_i),
  .eoi_i       (eoi_i),
  .count_o     (count_o),
  .active_o    (active_o),
  .rst_req_o   (rst_req_o),
  .rst_out_n_o (rst_out_n_o),
  .wd_status_o (wd_status_o)
);

// File: tb/wdog_lockable_bench.sv
module wdog_lockable_bench;
  localparam int CNT_W = 8;
  localparam int RL_W  = CNT_W / 2;
  localparam int DF    = 2;
  localparam int DS    = 8;
  localparam int PL    = 16;

  typedef struct {
    string req;
    int    val;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic svc = 0, dis = 0, eoi = 0, cfg_wr = 0, slow = 0, sclr = 0;
  logic [RL_W-1:0]  reload = '0;
  logic [CNT_W-1:0] count;
  logic active, req, rout_n, status;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;
  item_t exp_q[$];
  int    act_q[$];

  always #2 clk = ~clk;

  wdog_lockable #(.CNT_W(CNT_W), .DIV_FAST(DF), .DIV_SLOW(DS), .PULSE_LEN(PL)) u_wdog_lockable (
    .clk(clk), .rst(rst), .svc_i(svc), .dis_i(dis), .eoi_i(eoi),
    .cfg_wr_i(cfg_wr), .cfg_reload_i(reload), .cfg_slow_i(slow), .stat_clr_i(sclr),
    .count_o(count), .active_o(active), .rst_req_o(req), .rst_out_n_o(rout_n),
    .wd_status_o(status)
  );

  // scoreboard monitor: pairs expected items with observed values
  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e;
      int a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      checks++;
      if (a != e.val) begin
        errors++;
        $display("FAIL %s: actual=%0d expected=%0d", e.req, a, e.val);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_val(input string r, input int e, input int a);
    item_t it;
    it.req = r;
    it.val = e;
    exp_q.push_back(it);
    act_q.push_back(a);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1;
    @(posedge clk);
    #1 sig = 0;
  endtask

  task automatic write_cfg(input logic [RL_W-1:0] r, input logic s);
    @(negedge clk);
    reload = r;
    slow   = s;
    cfg_wr = 1;
    @(posedge clk);
    #1 cfg_wr = 0;
  endtask

  // count edges from the current point until rst_out_n is seen low
  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1 n++;
    end while (rout_n && n < 5000);
  endtask

  initial begin
    int n;
    int low;
    int reqs;
    @(posedge clk);
    @(posedge clk);
    #1;
    // R1: reset state
    expect_val("R1 active", 1, active);
    expect_val("R1 count", 0, count);
    expect_val("R1 rst_out_n", 1, rout_n);
    expect_val("R1 rst_req", 0, req);
    expect_val("R1 status", 0, status);
    rst = 0;

    // R3: default interval from reset release
    measure(n);
    expect_val("R3 default interval", (1 << CNT_W) * DF, n);
    // R7: request on the falling edge, pulse width; R11: commands during pulse
    expect_val("R7 req with fall", 1, req);
    expect_val("R9 status set", 1, status);
    low  = 1;
    reqs = 1;
    eoi = 1; cfg_wr = 1; reload = 4'hF; slow = 1;
    while (!rout_n && low < 100) begin
      @(posedge clk);
      #1;
      if (!rout_n) low++;
      if (req) reqs++;
    end
    eoi = 0; cfg_wr = 0;
    expect_val("R7 pulse width", PL, low);
    expect_val("R7 req single", 1, reqs);
    // R8: state restored
    expect_val("R8 active", 1, active);
    expect_val("R8 count", 0, count);
    // R11: ignored config -> reload still 0; ignored eoi -> disable works
    pulse(svc);
    expect_val("R11 reload unchanged", 0, count);
    pulse(dis);
    expect_val("R11 lock not set", 0, active);
    expect_val("R9 status held", 1, status);
    pulse(sclr);
    expect_val("R9 status cleared", 0, status);

    // R4/R2/R10: slow divider with reload E
    do_reset();
    write_cfg(4'hE, 1'b1);
    pulse(svc);
    expect_val("R4 load value", 8'hE0, count);
    measure(n);
    expect_val("R2 slow interval", (256 - 224) * DS, n);

    // R4: fast divider with reload F
    do_reset();
    write_cfg(4'hF, 1'b0);
    pulse(svc);
    expect_val("R4 load F", 8'hF0, count);
    measure(n);
    expect_val("R4 fast interval", 16 * DF, n);

    // R8: after overflow the default interval applies again
    do begin @(posedge clk); #1; end while (!rout_n);
    measure(n);
    expect_val("R8 default after overflow", (1 << CNT_W) * DF, n);

    // R5: disable before end of init
    do_reset();
    pulse(dis);
    expect_val("R5 inactive", 0, active);
    begin
      logic [CNT_W-1:0] c0;
      c0 = count;
      measure(n);
      expect_val("R5 no overflow", 5000, n);
      expect_val("R5 count frozen", c0, count);
    end

    // R6: disable ignored after end of init
    do_reset();
    pulse(eoi);
    pulse(eoi);
    pulse(dis);
    expect_val("R6 still active", 1, active);
    pulse(svc);
    measure(n);
    expect_val("R6 overflow continues", (1 << CNT_W) * DF, n);

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule